// File: doc/BRIEF.md
# Packet-Command Device Register Interface

This block is the device end of a disc-drive style packet-command register set. A host writes a feature flag pair and then a packet opcode to the command register. The block answers by asking for a 12-byte command packet, taken as six 16-bit PIO writes. Once the packet is complete it is presented on a parallel bus to a command handler and the device reports busy.

The handler writes any response data into an internal word-wide buffer. It then finishes with a 16-bit result code, a read flag, a byte length and a block size. A nonzero result ends the command with a check condition and records the code in a 10-byte sense record. A zero result with the read flag set starts a data-in phase. The feature DMA flag selects the transfer path. With the flag clear, the host reads the data one word at a time and is interrupted at every block boundary and at the end. With the flag set, a burst port asks for a byte count and receives at most the bytes that remain, one word per cycle.

Reading the status register withdraws a pending interrupt while the device is not busy.

Top module: `pkt_dev_if`

## Requirements
- R1: After reset the status, error, interrupt-reason and byte-count registers read 0x00, the interrupt line is low, all 80 bits of the sense record are zero, and a data read returns 0xFFFF.
- R2: Writing opcode PKT_OPCODE (default 0xA0) while idle sets status to 0x48 (ready 0x40 plus data-request 0x08), sets the interrupt-reason register to 0x01 and loads the error register with the two feature flags in bits [1:0].
- R3: The sixth data write of the command phase sets status to 0xC0 (busy 0x80 plus ready). It pulses pkt_valid_o high for exactly one cycle. It presents packet word k on pkt_data_o[16k+15:16k].
- R4: A handler finish with a nonzero result sets status to 0x51 and loads the error register with result[3:0] in bits [7:4]. It writes sense byte 0 = 0xF0, byte 2 = result[7:0] and byte 8 = result[15:8], with sense byte n on sense_o[8n+7:8n]. The block returns to idle.
- R5: A handler finish with a zero result and the read flag clear leaves status at 0x40, and later data reads return 0xFFFF.
- R6: A zero-result read finish with feature flag bit 0 clear sets status to 0x48 and the interrupt-reason register to 0x02. The byte-count registers receive length[7:0] (low) and length>>8 (high).
- R7: Each PIO data read returns the next buffer word in ascending address order, one cycle after the strobe. The read that reaches or passes the length returns status to 0x40 and raises the interrupt.
- R8: During a PIO read, the read that uses up the block size raises the interrupt and restarts the block count, while the transfer continues.
- R9: A data read while no PIO read is in progress returns 0xFFFF and changes no register.
- R10: A status read while the busy bit is clear drops the interrupt line on the next cycle.
- R11: A zero-result read finish with feature flag bit 0 set sets status to 0x68 (adding DMA-request 0x20) and the interrupt-reason register to 0x02.
- R12: A burst request acknowledges with min(requested, remaining) bytes, or 0 outside a DMA read. It then streams ceil(moved/2) words in ascending order on consecutive cycles, starting the cycle after the acknowledge.
- R13: The burst word that finishes the length returns status to 0x40, with DMA-request and data-request cleared, and raises the interrupt.
- R14: A packet opcode written outside idle, or a data write outside the command phase, leaves status, interrupt-reason, pkt_valid_o and the transfer in progress unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| feat_wr | input | 1 | Feature register write strobe |
| feat_wdata | input | 2 | Feature flags: bit 0 DMA, bit 1 overlap |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_wdata | input | 8 | Command opcode |
| stat_rd | input | 1 | Status register read strobe |
| status_o | output | 8 | Status register |
| error_o | output | 8 | Error register |
| count_o | output | 8 | Interrupt-reason register |
| bcnt_lo_o | output | 8 | Byte-count low register |
| bcnt_hi_o | output | 8 | Byte-count high register |
| data_wr | input | 1 | Data register write strobe |
| data_wdata | input | 16 | Data register write word |
| data_rd | input | 1 | Data register read strobe |
| data_rdata | output | 16 | Data word, valid the cycle after data_rd |
| pkt_valid_o | output | 1 | One-cycle pulse: packet complete |
| pkt_data_o | output | 96 | Captured packet, word k at [16k+15:16k] |
| hnd_wr | input | 1 | Handler buffer write enable |
| hnd_waddr | input | log2(BUF_BYTES)-1 | Handler buffer word address |
| hnd_wdata | input | 16 | Handler buffer write word |
| hnd_done | input | 1 | Handler finish strobe |
| hnd_result | input | 16 | Handler result code |
| hnd_read | input | 1 | Finish starts a data-in phase |
| hnd_len | input | log2(BUF_BYTES)+1 | Data-in length in bytes |
| hnd_blk | input | log2(BUF_BYTES)+1 | PIO block size in bytes |
| dma_req | input | 1 | Burst request strobe |
| dma_len | input | log2(BUF_BYTES)+1 | Requested burst bytes |
| dma_ack_o | output | 1 | Burst acknowledge pulse |
| dma_moved_o | output | log2(BUF_BYTES)+1 | Bytes granted to the burst |
| dma_valid_o | output | 1 | Burst word valid |
| dma_data_o | output | 16 | Burst word |
| irq_o | output | 1 | Interrupt line |
| sense_o | output | 80 | Sense record, byte n at [8n+7:8n] |

## Verification
The bench builds the block with BUF_BYTES set to 256 and the default opcode, so the whole buffer is 128 words. A transfer of the full buffer is therefore short enough to run in both the PIO and the burst path. That run reaches the top bit of the length, offset and byte-count fields. With small block sizes and burst requests, block-boundary interrupts, odd final lengths and partial last bursts all appear within a few short vectors.

// File: rtl/pktif_pkg.sv
// Shared encodings for the packet-command device interface.
// Assumes: state codes and status bit weights are fixed by the protocol.
package pktif_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_CMD_WR = 3'd1,
        ST_PIO_RD = 3'd2,
        ST_PIO_WR = 3'd3,
        ST_DMA_RD = 3'd4,
        ST_DMA_WR = 3'd5,
        ST_BUSY   = 3'd6
    } xfer_state_e;

    localparam logic [7:0] SB_BSY    = 8'h80;
    localparam logic [7:0] SB_DRDY   = 8'h40;
    localparam logic [7:0] SB_DMAREQ = 8'h20;
    localparam logic [7:0] SB_DRQ    = 8'h08;
    localparam logic [7:0] SB_CHK    = 8'h01;

    localparam logic [7:0] IR_CMD    = 8'h01;
    localparam logic [7:0] IR_IN     = 8'h02;

    localparam int PKT_WORDS = 6;

endpackage

// File: rtl/pktif_buf.sv
// Data buffer: one write port for the command handler and one
// synchronous read port for the transfer engine.
// Assumes: read data is valid the cycle after rd_en and holds afterwards.
module pktif_buf #(
    parameter int DEPTH = 2048,
    parameter int DW    = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);

    logic [DW-1:0] mem [DEPTH];

    // Handler-side word write.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    // Transfer-side registered word read.
    always_ff @(posedge clk) begin
        if (rd_en) rd_data <= mem[rd_addr];
    end

endmodule

// File: rtl/pktif_cmdcap.sv
// Command packet capture: collects WORDS data writes into a parallel bus.
// Assumes: clr restarts the word index; last_o marks the final word write.
module pktif_cmdcap #(
    parameter int WORDS = 6,
    localparam int IW   = $clog2(WORDS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                wr_en,
    input  logic [15:0]         wr_data,
    output logic                last_o,
    output logic [WORDS*16-1:0] pkt_o
);

    logic [IW-1:0] idx;

    assign last_o = wr_en && (idx == IW'(WORDS - 1));

    // Word index: restarts on clr and after the last word.
    always_ff @(posedge clk) begin
        if (!rst_n)      idx <= '0;
        else if (clr)    idx <= '0;
        else if (wr_en)  idx <= last_o ? '0 : idx + 1'b1;
    end

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        logic [15:0] word_q;
        // Holds packet word g.
        always_ff @(posedge clk) begin
            if (!rst_n)                          word_q <= '0;
            else if (wr_en && idx == IW'(g))     word_q <= wr_data;
        end
        assign pkt_o[g*16 +: 16] = word_q;
    end

    p_idx_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        idx < IW'(WORDS));

endmodule

// File: rtl/pktif_sense.sv
// Sense record: ten bytes updated from a 16-bit handler result.
// Assumes: bytes other than 0, 2 and 8 keep their values across loads.
module pktif_sense #(
    parameter int BYTES = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [15:0]        result,
    output logic [BYTES*8-1:0] sense_o
);

    logic [7:0] rec [BYTES];

    // Loads header, code and qualifier bytes on each handler finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < BYTES; i++) rec[i] <= 8'h00;
        end else if (load) begin
            rec[0] <= 8'hF0;
            rec[2] <= result[7:0];
            rec[8] <= result[15:8];
        end
    end

    for (genvar g = 0; g < BYTES; g++) begin : g_out
        assign sense_o[g*8 +: 8] = rec[g];
    end

    p_sense_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (sense_o[7:0] == 8'hF0) && (sense_o[23:16] == $past(result[7:0]))
                 && (sense_o[71:64] == $past(result[15:8])));

endmodule

// File: rtl/pkt_dev_if.sv
// Packet-command device interface: register set, command-phase capture,
// handler hand-off, PIO and burst data-in phases, interrupt and sense.
// Assumes: one host access per cycle; handler lengths fit the buffer.
module pkt_dev_if #(
    parameter int          BUF_BYTES  = 4096,
    parameter logic [7:0]  PKT_OPCODE = 8'hA0
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          feat_wr,
    input  logic [1:0]                    feat_wdata,
    input  logic                          cmd_wr,
    input  logic [7:0]                    cmd_wdata,
    input  logic                          stat_rd,
    output logic [7:0]                    status_o,
    output logic [7:0]                    error_o,
    output logic [7:0]                    count_o,
    output logic [7:0]                    bcnt_lo_o,
    output logic [7:0]                    bcnt_hi_o,
    input  logic                          data_wr,
    input  logic [15:0]                   data_wdata,
    input  logic                          data_rd,
    output logic [15:0]                   data_rdata,
    output logic                          pkt_valid_o,
    output logic [95:0]                   pkt_data_o,
    input  logic                          hnd_wr,
    input  logic [$clog2(BUF_BYTES)-2:0]  hnd_waddr,
    input  logic [15:0]                   hnd_wdata,
    input  logic                          hnd_done,
    input  logic [15:0]                   hnd_result,
    input  logic                          hnd_read,
    input  logic [$clog2(BUF_BYTES):0]    hnd_len,
    input  logic [$clog2(BUF_BYTES):0]    hnd_blk,
    input  logic                          dma_req,
    input  logic [$clog2(BUF_BYTES):0]    dma_len,
    output logic                          dma_ack_o,
    output logic [$clog2(BUF_BYTES):0]    dma_moved_o,
    output logic                          dma_valid_o,
    output logic [15:0]                   dma_data_o,
    output logic                          irq_o,
    output logic [79:0]                   sense_o
);
    import pktif_pkg::*;

    localparam int LW    = $clog2(BUF_BYTES) + 1;
    localparam int AW    = LW - 2;
    localparam int WORDS = BUF_BYTES / 2;

    xfer_state_e   state;
    logic [7:0]    status_q, error_q, count_q, bcnt_lo_q, bcnt_hi_q;
    logic [1:0]    feat_q;
    logic [LW-1:0] offset, xfer_len, blk_len, blk_left, burst_left;
    logic          irq_q, pkt_valid_q, bad_q;
    logic          dma_ack_q, dma_valid_q;
    logic [LW-1:0] dma_moved_q;
    logic [15:0]   ram_q;

    logic          cmd_go, cap_wr, cap_last, pio_go, hnd_go;
    logic          dma_step, dma_grant, pio_last, dma_last;
    logic [LW-1:0] remain, dma_amt, step_take;

    // Event decode for the current state.
    always_comb begin
        cmd_go    = cmd_wr && (cmd_wdata == PKT_OPCODE) && (state == ST_IDLE);
        cap_wr    = data_wr && (state == ST_CMD_WR);
        pio_go    = data_rd && (state == ST_PIO_RD);
        hnd_go    = hnd_done && (state == ST_BUSY);
        dma_step  = (state == ST_DMA_RD) && (burst_left != '0);
        dma_grant = dma_req && (state == ST_DMA_RD) && (burst_left == '0);
        remain    = xfer_len - offset;
        dma_amt   = (dma_len < remain) ? dma_len : remain;
        step_take = (burst_left >= LW'(2)) ? LW'(2) : burst_left;
        pio_last  = (offset + LW'(2)) >= xfer_len;
        dma_last  = (offset + step_take) >= xfer_len;
    end

    pktif_cmdcap #(.WORDS(PKT_WORDS)) i_cmdcap (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (cmd_go),
        .wr_en   (cap_wr),
        .wr_data (data_wdata),
        .last_o  (cap_last),
        .pkt_o   (pkt_data_o)
    );

    pktif_buf #(.DEPTH(WORDS), .DW(16)) i_buf (
        .clk     (clk),
        .wr_en   (hnd_wr),
        .wr_addr (hnd_waddr),
        .wr_data (hnd_wdata),
        .rd_en   (pio_go || dma_step),
        .rd_addr (offset[AW:1]),
        .rd_data (ram_q)
    );

    pktif_sense #(.BYTES(10)) i_sense (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (hnd_go),
        .result  (hnd_result),
        .sense_o (sense_o)
    );

    // Transfer state machine and register file.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            status_q    <= 8'h00;
            error_q     <= 8'h00;
            count_q     <= 8'h00;
            bcnt_lo_q   <= 8'h00;
            bcnt_hi_q   <= 8'h00;
            feat_q      <= 2'b00;
            offset      <= '0;
            xfer_len    <= '0;
            blk_len     <= '0;
            blk_left    <= '0;
            burst_left  <= '0;
            irq_q       <= 1'b0;
            pkt_valid_q <= 1'b0;
            bad_q       <= 1'b1;
            dma_ack_q   <= 1'b0;
            dma_valid_q <= 1'b0;
            dma_moved_q <= '0;
        end else begin
            pkt_valid_q <= 1'b0;
            dma_ack_q   <= 1'b0;
            dma_valid_q <= dma_step;
            if (feat_wr) feat_q <= feat_wdata;
            if (stat_rd && !status_q[7]) irq_q <= 1'b0;
            if (data_rd) bad_q <= (state != ST_PIO_RD);
            if (dma_req && state != ST_DMA_RD) begin
                dma_ack_q   <= 1'b1;
                dma_moved_q <= '0;
            end
            case (state)
                ST_IDLE: begin
                    if (cmd_go) begin
                        state    <= ST_CMD_WR;
                        status_q <= SB_DRDY | SB_DRQ;
                        error_q  <= {6'b0, feat_q};
                        count_q  <= IR_CMD;
                        offset   <= '0;
                    end
                end
                ST_CMD_WR: begin
                    if (cap_wr) begin
                        offset <= offset + LW'(2);
                        if (cap_last) begin
                            state       <= ST_BUSY;
                            status_q    <= (status_q & ~SB_DRQ) | SB_BSY;
                            pkt_valid_q <= 1'b1;
                            offset      <= '0;
                        end
                    end
                end
                ST_BUSY: begin
                    if (hnd_go) begin
                        error_q <= {hnd_result[3:0], 4'b0};
                        if (hnd_result != 16'h0000) begin
                            status_q <= 8'h51;
                            state    <= ST_IDLE;
                        end else if (hnd_read) begin
                            status_q <= SB_DRDY | SB_DRQ | (feat_q[0] ? SB_DMAREQ : 8'h00);
                            count_q  <= IR_IN;
                            offset   <= '0;
                            xfer_len <= hnd_len;
                            blk_len  <= hnd_blk;
                            blk_left <= hnd_blk;
                            if (feat_q[0]) begin
                                state <= ST_DMA_RD;
                            end else begin
                                state     <= ST_PIO_RD;
                                bcnt_lo_q <= hnd_len[7:0];
                                bcnt_hi_q <= 8'(hnd_len >> 8);
                            end
                        end else begin
                            status_q <= status_q & ~(SB_BSY | SB_CHK);
                            state    <= ST_IDLE;
                        end
                    end
                end
                ST_PIO_RD: begin
                    if (pio_go) begin
                        offset <= offset + LW'(2);
                        if (pio_last) begin
                            state    <= ST_IDLE;
                            status_q <= status_q & ~SB_DRQ;
                            irq_q    <= 1'b1;
                        end else if (blk_left <= LW'(2)) begin
                            blk_left <= blk_len;
                            irq_q    <= 1'b1;
                        end else begin
                            blk_left <= blk_left - LW'(2);
                        end
                    end
                end
                ST_DMA_RD: begin
                    if (dma_grant) begin
                        dma_ack_q   <= 1'b1;
                        dma_moved_q <= dma_amt;
                        burst_left  <= dma_amt;
                    end else if (dma_step) begin
                        offset     <= offset + step_take;
                        burst_left <= burst_left - step_take;
                        if (dma_last) begin
                            state      <= ST_IDLE;
                            status_q   <= status_q & ~(SB_DRQ | SB_DMAREQ);
                            irq_q      <= 1'b1;
                            burst_left <= '0;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign status_o    = status_q;
    assign error_o     = error_q;
    assign count_o     = count_q;
    assign bcnt_lo_o   = bcnt_lo_q;
    assign bcnt_hi_o   = bcnt_hi_q;
    assign data_rdata  = bad_q ? 16'hFFFF : ram_q;
    assign pkt_valid_o = pkt_valid_q;
    assign dma_ack_o   = dma_ack_q;
    assign dma_moved_o = dma_moved_q;
    assign dma_valid_o = dma_valid_q;
    assign dma_data_o  = ram_q;
    assign irq_o       = irq_q;

    p_cmd_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd_wdata == PKT_OPCODE && state == ST_IDLE)
        |=> (status_o == 8'h48) && (count_o == 8'h01));

    p_pkt_phase_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid_o |-> (state == ST_BUSY) && ($past(state) == ST_CMD_WR));

    p_fail_status_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (hnd_done && state == ST_BUSY && hnd_result != 16'h0000)
        |=> (status_o == 8'h51) && (state == ST_IDLE));

    p_pio_end_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_PIO_RD && state == ST_IDLE) |-> irq_o);

    p_idle_no_drq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !status_o[3]);

    p_bad_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && state != ST_PIO_RD) |=> (data_rdata == 16'hFFFF));

    p_irq_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !status_o[7] && state == ST_IDLE) |=> !irq_o);

    p_dma_limit_r12: assert property (@(posedge clk) disable iff (!rst_n)
        dma_ack_o |-> (dma_moved_o <= $past(dma_len)));

endmodule

// File: tb/test_pkt_dev_if.sv
module test_pkt_dev_if;

    localparam int BUF_BYTES = 256;
    localparam int LW        = $clog2(BUF_BYTES) + 1;
    localparam int AW        = LW - 2;

    typedef struct packed {
        logic        dma;
        logic [15:0] len;
        logic [15:0] blk;
        logic [15:0] req;
        logic [15:0] seed;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 16'd12,  16'd12,  16'd0,   16'h1000},
        '{1'b0, 16'd20,  16'd6,   16'd0,   16'h2000},
        '{1'b0, 16'd7,   16'd64,  16'd0,   16'h3000},
        '{1'b1, 16'd20,  16'd0,   16'd8,   16'h4000},
        '{1'b1, 16'd256, 16'd0,   16'd100, 16'h5000},
        '{1'b1, 16'd9,   16'd0,   16'd4,   16'h6000},
        '{1'b0, 16'd256, 16'd256, 16'd0,   16'h7000}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic feat_wr = 0; logic [1:0] feat_wdata = 0;
    logic cmd_wr = 0;  logic [7:0] cmd_wdata = 0;
    logic stat_rd = 0;
    logic [7:0] status_o, error_o, count_o, bcnt_lo_o, bcnt_hi_o;
    logic data_wr = 0; logic [15:0] data_wdata = 0;
    logic data_rd = 0; logic [15:0] data_rdata;
    logic pkt_valid_o; logic [95:0] pkt_data_o;
    logic hnd_wr = 0; logic [AW-1:0] hnd_waddr = 0; logic [15:0] hnd_wdata = 0;
    logic hnd_done = 0; logic [15:0] hnd_result = 0; logic hnd_read = 0;
    logic [LW-1:0] hnd_len = 0, hnd_blk = 0;
    logic dma_req = 0; logic [LW-1:0] dma_len = 0;
    logic dma_ack_o; logic [LW-1:0] dma_moved_o;
    logic dma_valid_o; logic [15:0] dma_data_o;
    logic irq_o; logic [79:0] sense_o;

    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    pkt_dev_if #(.BUF_BYTES(BUF_BYTES)) i_pkt_dev_if (.*);

    task automatic chk(input string req, input logic [95:0] act, input logic [95:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] pat(input logic [15:0] s, input int i);
        return s + 16'(i * 3);
    endfunction

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic put_feat(input logic [1:0] f);
        @(negedge clk); feat_wr = 1; feat_wdata = f;
        @(negedge clk); feat_wr = 0;
    endtask

    task automatic put_cmd(input logic [7:0] c);
        @(negedge clk); cmd_wr = 1; cmd_wdata = c;
        @(negedge clk); cmd_wr = 0;
    endtask

    task automatic put_data(input logic [15:0] w);
        @(negedge clk); data_wr = 1; data_wdata = w;
        @(negedge clk); data_wr = 0;
    endtask

    task automatic get_data();
        @(negedge clk); data_rd = 1;
        @(negedge clk); data_rd = 0;
    endtask

    task automatic read_status();
        @(negedge clk); stat_rd = 1;
        @(negedge clk); stat_rd = 0;
    endtask

    task automatic finish(input logic [15:0] res, input logic rd,
                          input logic [15:0] len, input logic [15:0] blk);
        @(negedge clk); hnd_done = 1; hnd_result = res; hnd_read = rd;
        hnd_len = LW'(len); hnd_blk = LW'(blk);
        @(negedge clk); hnd_done = 0;
    endtask

    task automatic burst(input logic [15:0] n);
        @(negedge clk); dma_req = 1; dma_len = LW'(n);
        @(negedge clk); dma_req = 0;
    endtask

    task automatic fill(input logic [15:0] seed, input int nwords);
        for (int i = 0; i < nwords; i++) begin
            @(negedge clk); hnd_wr = 1; hnd_waddr = AW'(i); hnd_wdata = pat(seed, i);
        end
        @(negedge clk); hnd_wr = 0;
    endtask

    // Opcode, six packet words, checks of both phases.
    task automatic send_packet(input logic [15:0] seed, input logic [1:0] feat);
        logic [95:0] exp_pkt;
        put_cmd(8'hA0);
        chk("R2 status", status_o, 8'h48);
        chk("R2 count", count_o, 8'h01);
        chk("R2 error", error_o, {6'b0, feat});
        for (int k = 0; k < 6; k++) begin
            put_data(seed ^ 16'(k));
            exp_pkt[k*16 +: 16] = seed ^ 16'(k);
        end
        chk("R3 pkt_valid", pkt_valid_o, 1'b1);
        chk("R3 status", status_o, 8'hC0);
        chk("R3 pkt_data", pkt_data_o, exp_pkt);
        tick();
        chk("R3 pulse width", pkt_valid_o, 1'b0);
    endtask

    task automatic run_vec(input vec_t v);
        int done;
        int bl;
        int amt;
        logic exp_irq;
        put_feat(v.dma ? 2'b01 : 2'b10);
        send_packet(v.seed, v.dma ? 2'b01 : 2'b10);
        fill(v.seed, (int'(v.len) + 1) / 2);
        finish(16'h0000, 1'b1, v.len, v.blk);
        chk(v.dma ? "R11 count" : "R6 count", count_o, 8'h02);
        if (!v.dma) begin
            chk("R6 status", status_o, 8'h48);
            chk("R6 bcnt_lo", bcnt_lo_o, v.len[7:0]);
            chk("R6 bcnt_hi", bcnt_hi_o, v.len[15:8]);
            done = 0;
            bl = int'(v.blk);
            while (done < int'(v.len)) begin
                get_data();
                chk("R7 word", data_rdata, pat(v.seed, done / 2));
                done += 2;
                exp_irq = 1'b0;
                if (done >= int'(v.len)) exp_irq = 1'b1;
                else begin
                    bl -= 2;
                    if (bl <= 0) begin bl = int'(v.blk); exp_irq = 1'b1; end
                end
                chk("R8 irq", irq_o, exp_irq);
                if (exp_irq) begin
                    read_status();
                    chk("R10 irq cleared", irq_o, 1'b0);
                end
            end
            chk("R7 end status", status_o, 8'h40);
        end else begin
            chk("R11 status", status_o, 8'h68);
            done = 0;
            while (done < int'(v.len)) begin
                amt = int'(v.len) - done;
                if (int'(v.req) < amt) amt = int'(v.req);
                burst(v.req);
                chk("R12 ack", dma_ack_o, 1'b1);
                chk("R12 moved", dma_moved_o, LW'(amt));
                for (int w = 0; w < (amt + 1) / 2; w++) begin
                    tick();
                    chk("R12 valid", dma_valid_o, 1'b1);
                    chk("R12 word", dma_data_o, pat(v.seed, done / 2 + w));
                end
                done += amt;
            end
            chk("R13 status", status_o, 8'h40);
            chk("R13 irq", irq_o, 1'b1);
            read_status();
            chk("R10 irq cleared", irq_o, 1'b0);
        end
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1;
        tick();
        // R1 reset state
        chk("R1 status", status_o, 8'h00);
        chk("R1 error", error_o, 8'h00);
        chk("R1 count", count_o, 8'h00);
        chk("R1 bcnt", {bcnt_hi_o, bcnt_lo_o}, 16'h0000);
        chk("R1 irq", irq_o, 1'b0);
        chk("R1 sense", sense_o, 80'h0);
        get_data();
        chk("R1 data read", data_rdata, 16'hFFFF);

        // R12 burst request outside a DMA read
        burst(16'd8);
        chk("R12 idle ack", dma_ack_o, 1'b1);
        chk("R12 idle moved", dma_moved_o, '0);

        // Table of transfers
        for (int i = 0; i < NV; i++) run_vec(VEC[i]);

        // R4 nonzero result
        put_feat(2'b00);
        send_packet(16'hABCD, 2'b00);
        finish(16'h3A05, 1'b1, 16'd8, 16'd8);
        chk("R4 status", status_o, 8'h51);
        chk("R4 error", error_o, 8'h50);
        chk("R4 sense0", sense_o[7:0], 8'hF0);
        chk("R4 sense1", sense_o[15:8], 8'h00);
        chk("R4 sense2", sense_o[23:16], 8'h05);
        chk("R4 sense8", sense_o[71:64], 8'h3A);
        get_data();
        chk("R9 after error", data_rdata, 16'hFFFF);

        // R5 zero result, no data
        send_packet(16'h0F0F, 2'b00);
        finish(16'h0000, 1'b0, 16'd0, 16'd0);
        chk("R5 status", status_o, 8'h40);
        chk("R5 sense2", sense_o[23:16], 8'h00);
        get_data();
        chk("R5 data", data_rdata, 16'hFFFF);
        chk("R9 status kept", status_o, 8'h40);

        // R14 data write while idle is ignored
        put_data(16'h5555);
        chk("R14 pkt_valid", pkt_valid_o, 1'b0);
        chk("R14 idle status", status_o, 8'h40);

        // R14 opcode during a PIO read is ignored
        send_packet(16'h1234, 2'b00);
        fill(16'h0800, 4);
        finish(16'h0000, 1'b1, 16'd8, 16'd8);
        get_data();
        chk("R7 word", data_rdata, pat(16'h0800, 0));
        put_cmd(8'hA0);
        chk("R14 status", status_o, 8'h48);
        chk("R14 count", count_o, 8'h02);
        put_data(16'h9999);
        chk("R14 no packet", pkt_valid_o, 1'b0);
        for (int k = 1; k < 4; k++) begin
            get_data();
            chk("R14 transfer continues", data_rdata, pat(16'h0800, k));
        end
        chk("R7 end status", status_o, 8'h40);
        chk("R7 end irq", irq_o, 1'b1);
        read_status();
        chk("R10 irq cleared", irq_o, 1'b0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule